// File: doc/BRIEF.md
# Serial Register-File Slave for a Timekeeper

This block is the two-wire serial slave that sits in front of a timekeeping core. It watches oversampled clock and data lines, recognises bus start, stop and repeated-start conditions, and answers a single fixed 7-bit device address. Behind the address sits a 64-location register space. The low eight locations mirror the time, calendar and control registers of the timekeeping core. The remaining 56 locations are general-purpose byte storage held inside the block.

A write transfer sets an internal location pointer with its first data byte. Each later byte is stored at the pointer, and the pointer then steps forward. Bytes aimed at the time locations are passed to the core as a one-cycle write strobe, carrying the location and the value. A read transfer returns bytes from the pointer onward, with the pointer stepping after each byte. The time locations are served from a frozen copy of the core's live counters, so a burst read sees one consistent instant even while the core keeps counting. A power-fail input silences the slave completely while it is asserted.

Top module: `rtc_i2c_regif`

## Requirements
- R1: Only an address byte whose upper seven bits are 1101000 is acknowledged; bit 0 of that byte selects the direction (0 write, 1 read). Any other address gets no acknowledge and the transfer is ignored.
- R2: In a write transfer the first byte after the address loads the location pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R3: A byte written to locations 00h to 07h produces a single-cycle `wr_stb` carrying `wr_addr` and `wr_data`, issued as the slave starts its acknowledge for that byte. Bytes for 08h to 3Fh are kept in internal storage and raise no strobe.
- R4: The pointer steps from 3Fh to 00h, for both reads and writes.
- R5: Locations 00h to 07h read from a copy of `time_live` (byte i at bits 8i+7..8i). The copy is refreshed on every START (including repeated START), on every STOP, and whenever the pointer steps to 00h.
- R6: A read transfer that does not set the pointer first starts at the pointer value already held. The pointer increments after each byte sent.
- R7: When the master answers a read byte with NACK, the slave stops sending and leaves SDA released.
- R8: Unused bits of the time locations read as 0. The kept-bit masks for locations 0 to 7 are FF, 7F, 7F, 07, 3F, 1F, FF and B3 (hex).
- R9: While `pwr_fail` is high, the slave acknowledges nothing, issues no strobe, and releases SDA from the next clock onward.
- R10: A repeated START, even in the middle of a byte, abandons the current byte and returns to address matching. The pointer is left as it was.
- R11: After reset, SDA is released, no strobe is active, and the pointer is 00h.
- R12: Bytes are shifted most significant bit first, each followed by one acknowledge bit. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (open drain) |
| pwr_fail | input | 1 | Supply below threshold; blocks all access |
| time_live | input | 64 | Live contents of the eight time/control locations |
| wr_stb | output | 1 | One-cycle commit strobe for a time-location write |
| wr_addr | output | 6 | Location being committed |
| wr_data | output | 8 | Value being committed |

## Verification
The bench builds the block with its default parameters: device address 68h, a 6-bit pointer and eight time locations. With these values the 3Fh-to-00h wrap takes only a two-byte burst, and every kept-bit mask can be read in one eight-byte sweep. The bench drives the bus with a quarter-bit period of eight system clocks. That leaves room for the two-stage synchroniser and the edge register, so acknowledge and read data settle well before the master samples them. Because `time_live` is changed in the middle of bursts, it shows which refresh event loaded the copy that was read.

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif #(
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter int         REG_AW    = 6,
  parameter int         TIME_REGS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic                     pwr_fail,
  input  logic [8*TIME_REGS-1:0]   time_live,
  output logic                     wr_stb,
  output logic [REG_AW-1:0]        wr_addr,
  output logic [7:0]               wr_data
);
  localparam int NREG  = 1 << REG_AW;
  localparam int RAM_N = NREG - TIME_REGS;
  localparam int TW    = $clog2(TIME_REGS);
  localparam logic [REG_AW-1:0] LAST = REG_AW'(NREG - 1);
  localparam logic [REG_AW-1:0] TBASE = REG_AW'(TIME_REGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK} st_t;

  logic [2:0] scl_q, sda_q;
  st_t st;
  logic [3:0] bcnt;
  logic [7:0] sh, tx;
  logic [REG_AW-1:0] ptr;
  logic rw, have_ptr, nack;
  logic [7:0] shadow [TIME_REGS];
  logic [7:0] ram [RAM_N];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_s   = scl_q[1];
  wire scl_p   = scl_q[2];
  wire sda_s   = sda_q[1];
  wire sda_p   = sda_q[2];
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire live    = ~pwr_fail & ~start_c & ~stop_c;

  wire wr_commit = live & (st == S_WBYTE) & fall & (bcnt == 4'd8) & have_ptr;
  wire rd_adv    = live & (st == S_RBYTE) & fall & (bcnt == 4'd7);
  wire in_time   = ptr < TBASE;
  wire snap      = start_c | stop_c | ((wr_commit | rd_adv) & (ptr == LAST));
  wire [REG_AW-1:0] ram_idx = ptr - TBASE;

  function automatic logic [7:0] keep_bits(input logic [REG_AW-1:0] a);
    case (int'(a))
      0: return 8'hFF;
      1: return 8'h7F;
      2: return 8'h7F;
      3: return 8'h07;
      4: return 8'h3F;
      5: return 8'h1F;
      6: return 8'hFF;
      7: return 8'hB3;
      default: return 8'hFF;
    endcase
  endfunction

  wire [7:0] rd_byte = in_time ? (shadow[ptr[TW-1:0]] & keep_bits(ptr)) : ram[ram_idx];

  assign sda_oe = (st == S_AACK) | (st == S_WACK) | ((st == S_RBYTE) & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < TIME_REGS; i++) shadow[i] <= 8'h00;
    end else if (snap) begin
      for (int i = 0; i < TIME_REGS; i++) shadow[i] <= time_live[8*i +: 8];
    end

  always_ff @(posedge clk)
    if (wr_commit && !in_time) ram[ram_idx] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; have_ptr <= 1'b0; nack <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (pwr_fail) st <= S_IDLE;
      else if (start_c) begin st <= S_ADDR; bcnt <= '0; end
      else if (stop_c) st <= S_IDLE;
      else case (st)
        S_ADDR:
          if (rise) begin sh <= {sh[6:0], sda_s}; bcnt <= bcnt + 4'd1; end
          else if (fall && bcnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin st <= S_AACK; rw <= sh[0]; end
            else st <= S_IDLE;
          end
        S_AACK:
          if (fall) begin
            bcnt <= '0;
            if (rw) begin st <= S_RBYTE; tx <= rd_byte; end
            else begin st <= S_WBYTE; have_ptr <= 1'b0; end
          end
        S_WBYTE:
          if (rise) begin sh <= {sh[6:0], sda_s}; bcnt <= bcnt + 4'd1; end
          else if (fall && bcnt == 4'd8) begin
            st <= S_WACK;
            if (!have_ptr) begin ptr <= sh[REG_AW-1:0]; have_ptr <= 1'b1; end
            else begin
              if (in_time) begin wr_stb <= 1'b1; wr_addr <= ptr; wr_data <= sh; end
              ptr <= ptr + 1'b1;
            end
          end
        S_WACK:
          if (fall) begin st <= S_WBYTE; bcnt <= '0; end
        S_RBYTE:
          if (fall) begin
            if (bcnt == 4'd7) begin st <= S_RACK; ptr <= ptr + 1'b1; end
            else begin tx <= {tx[6:0], 1'b0}; bcnt <= bcnt + 4'd1; end
          end
        S_RACK:
          if (rise) nack <= sda_s;
          else if (fall) begin
            if (nack) st <= S_IDLE;
            else begin st <= S_RBYTE; tx <= rd_byte; bcnt <= '0; end
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/rtc_i2c_regif_chk.sv
module rtc_i2c_regif_chk #(
  parameter int REG_AW    = 6,
  parameter int TIME_REGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_fail,
  input logic              sda_oe,
  input logic              wr_stb,
  input logic [REG_AW-1:0] wr_addr,
  input logic              scl_s
);
  AST_PF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe); // R9
  AST_PF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !wr_stb); // R9
  AST_STROBE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr < REG_AW'(TIME_REGS))); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R3
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(pwr_fail)) |-> !$past(scl_s)); // R12
endmodule

bind rtc_i2c_regif rtc_i2c_regif_chk #(.REG_AW(REG_AW), .TIME_REGS(TIME_REGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .scl_s(scl_q[1])
);

// File: tb/rtc_i2c_regif_tb_top.sv
module rtc_i2c_regif_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
  logic [63:0] time_live = '0;
  logic sda_oe, wr_stb;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0, cyc = 0, stb_cnt = 0;
  logic [5:0] last_addr;
  logic [7:0] last_data;
  bit done = 0;

  logic [7:0] mk [8] = '{8'hFF, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'hB3};
  logic [63:0] t1 = 64'h10_24_02_28_04_23_59_30;
  logic [63:0] t2 = 64'h13_25_03_29_05_01_07_45;

  rtc_i2c_regif dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .time_live(time_live), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (wr_stb) begin stb_cnt++; last_addr = wr_addr; last_data = wr_data; end
    if (cyc > 150000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic put_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic get_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq(); endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~give_ack);
  endtask

  task automatic set_ptr_then_read(input logic [5:0] p);
    logic a;
    bus_start(); send_byte(8'hD0, a); send_byte({2'b00, p}, a);
    bus_start(); send_byte(8'hD1, a);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] v;
    chk("R11 sda released", sda_oe, 1'b0);
    chk("R11 no strobe", wr_stb, 1'b0);
    time_live = t1;
    bus_start(); send_byte(8'hD1, a); recv_byte(v, 1'b0); bus_stop();
    chk("R11 pointer starts at 00", v, t1[7:0] & mk[0]);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start(); send_byte(8'hA0, a); bus_stop();
    chk("R1 foreign address not acked", a, 1'b0);
    bus_start(); send_byte(8'hD0, a); bus_stop();
    chk("R1 own address acked", a, 1'b1);
  endtask

  task automatic t_ram_rw();
    logic a; logic [7:0] v;
    int s0 = stb_cnt;
    bus_start(); send_byte(8'hD0, a); send_byte(8'h10, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h96, a);
    send_byte(8'h77, a); send_byte(8'h00, a); bus_stop();
    chk("R3 storage writes raise no strobe", stb_cnt, s0);
    set_ptr_then_read(6'h10);
    recv_byte(v, 1'b1); chk("R2 byte at 10h", v, 8'h11);
    recv_byte(v, 1'b1); chk("R2 byte at 11h", v, 8'h22);
    recv_byte(v, 1'b0); chk("R12 msb-first pattern at 12h", v, 8'h96);
    bus_stop();
  endtask

  task automatic t_cur_read_nack();
    logic a; logic [7:0] v;
    bus_start(); send_byte(8'hD1, a); recv_byte(v, 1'b0);
    chk("R6 current read continues at 13h", v, 8'h77);
    for (int i = 0; i < 4; i++) begin
      wq();
      chk("R7 SDA released after NACK", sda_oe, 1'b0);
    end
    bus_stop();
  endtask

  task automatic t_time_write();
    logic a;
    int s0 = stb_cnt;
    bus_start(); send_byte(8'hD0, a); send_byte(8'h02, a);
    send_byte(8'h45, a);
    chk("R3 strobe by end of first ack", stb_cnt, s0 + 1);
    chk("R3 first strobe address", last_addr, 6'h02);
    send_byte(8'h12, a); bus_stop();
    chk("R3 strobe count", stb_cnt, s0 + 2);
    chk("R3 last strobe address", last_addr, 6'h03);
    chk("R3 last strobe data", last_data, 8'h12);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    time_live = '1;
    set_ptr_then_read(6'h00);
    for (int i = 0; i < 8; i++) begin
      recv_byte(v, i != 7);
      chk($sformatf("R8 mask loc %0d", i), v, mk[i]);
    end
    bus_stop();
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    time_live = t1;
    set_ptr_then_read(6'h00);
    recv_byte(v, 1'b1);
    chk("R5 loc 0 from copy", v, t1[7:0] & mk[0]);
    time_live = t2;
    for (int i = 1; i < 8; i++) begin
      recv_byte(v, i != 7);
      chk($sformatf("R5 frozen loc %0d", i), v, t1[8*i +: 8] & mk[i]);
    end
    bus_stop();
    set_ptr_then_read(6'h00);
    recv_byte(v, 1'b0); bus_stop();
    chk("R5 refreshed on next START", v, t2[7:0] & mk[0]);
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] v;
    int s0 = stb_cnt;
    bus_start(); send_byte(8'hD0, a); send_byte(8'h3F, a);
    send_byte(8'hAB, a); send_byte(8'h5A, a); bus_stop();
    chk("R4 write wraps to loc 0", last_addr, 6'h00);
    chk("R4 wrapped strobe data", last_data, 8'h5A);
    chk("R4 one strobe", stb_cnt, s0 + 1);
    time_live = t1;
    set_ptr_then_read(6'h3F);
    time_live = t2;
    recv_byte(v, 1'b1);
    chk("R4 read at 3Fh", v, 8'hAB);
    recv_byte(v, 1'b0); bus_stop();
    chk("R5 copy refreshed at wrap", v, t2[7:0] & mk[0]);
  endtask

  task automatic t_pwr();
    logic a;
    int s0 = stb_cnt;
    pwr_fail = 1;
    bus_start(); send_byte(8'hD0, a);
    chk("R9 no ack under power fail", a, 1'b0);
    send_byte(8'h00, a); send_byte(8'h99, a); bus_stop();
    chk("R9 no strobe under power fail", stb_cnt, s0);
    pwr_fail = 0;
    bus_start(); send_byte(8'hD0, a); bus_stop();
    chk("R9 ack resumes after power returns", a, 1'b1);
  endtask

  task automatic t_rs_abort();
    logic a; logic [7:0] v;
    bus_start(); send_byte(8'hD0, a); send_byte(8'h20, a); send_byte(8'h55, a); bus_stop();
    bus_start(); send_byte(8'hD0, a); send_byte(8'h20, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start(); send_byte(8'hD1, a);
    chk("R10 address acked after mid-byte restart", a, 1'b1);
    recv_byte(v, 1'b0); bus_stop();
    chk("R10 partial byte discarded", v, 8'h55);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_ram_rw();
    t_cur_read_nack();
    t_time_write();
    t_masks();
    t_snapshot();
    t_wrap();
    t_pwr();
    t_rs_abort();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule